// File: doc/BRIEF.md
# Data-Processing Execute and Writeback Unit

This unit executes one data-processing instruction of a 32-bit RISC core per accepted transfer. It takes already decoded fields (opcode, flag-set bit, destination index, operand selection, rotated 8-bit immediate, shift controls) together with the register values, the instruction address, the current mode and the current and saved status words. It builds the second operand in a barrel shifter, runs the ALU and decides the writeback. The writeback is a register-file write, a program-counter write, or neither. It also produces the next status word, either with updated condition flags or as an atomic restore from the saved status word.

Instructions enter on a valid/ready handshake, and results leave through a one-entry output register with its own valid/ready handshake. An instruction is taken when `in_valid` and `in_ready` are both high at a clock edge. Its result appears on the following cycle and is held unchanged while `out_ready` is low. `in_ready` is low only when a result is waiting and the consumer is not taking it, so back-pressure stalls the producer without losing data. The status word layout is N at bit 31, Z at bit 30, C at bit 29, V at bit 28, and the mode in bits 4:0; User mode is 5'b10000, and every other mode is privileged.

Top module: `dpu_exec`

## Requirements
- R1: With `use_imm`=1, operand 2 is `imm8` zero-extended to 32 bits and rotated right by 2×`imm_rot` (0 to 30). The shifter carry equals the current C flag when `imm_rot`=0, and otherwise equals bit 31 of the rotated value.
- R2: With `use_imm`=0, operand 2 is the Rm value shifted by `sh_type` (0 LSL, 1 LSR, 2 ASR, 3 ROR). The amount is `sh_amt[4:0]` when `sh_by_reg`=0 and `sh_amt[7:0]` when `sh_by_reg`=1. An amount of zero passes the value through with carry equal to C, with these exceptions for instruction amounts: LSR 0 and ASR 0 mean a shift by 32, and ROR 0 means rotate right one bit through C. The carry is the last bit shifted out.
- R3: The opcode codes are 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. `res_data` carries the ALU result, even when nothing is written.
- R4: For logical opcodes, N and Z follow the result, C is the shifter carry and V keeps its current value.
- R5: For arithmetic opcodes, C is the adder carry-out (for subtraction, 1 means no borrow) and V is signed overflow.
- R6: When the destination is not 15 and the opcode is not a test, `rf_we`=1. If `set_flags`=1, bits 31:28 of the status word take the new flags; otherwise the status word passes unchanged. Bits 27:0 are never altered by a flag update.
- R7: Destination 15 with `set_flags`=0 on a non-test opcode gives `pc_we`=1, `rf_we`=0 and an unchanged status word.
- R8: Destination 15 with `set_flags`=1 on a non-test opcode gives `pc_we`=1. The next status word equals the saved status word in a privileged mode and equals the current one in User mode.
- R9: A source index of 15 (`rn_idx` or `rm_idx`) reads the instruction address plus 8, or plus 12 when `use_imm`=0 and `sh_by_reg`=1.
- R10: The test opcodes (8 to 11) never assert `rf_we` or `pc_we`, and they update the flags whatever the value of `set_flags`.
- R11: TEQ with destination 15 copies the saved status word into the status output in a privileged mode, and leaves it unchanged in User mode.
- R12: `in_ready` = !`out_valid` | `out_ready`. An accepted instruction shows `out_valid`=1 on the next cycle, and all outputs hold steady while `out_valid`=1 and `out_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction fields are valid |
| in_ready | output | 1 | Unit can take an instruction |
| op | input | 4 | Opcode |
| set_flags | input | 1 | Flag-set bit |
| rd_idx | input | 4 | Destination register index |
| use_imm | input | 1 | 1: rotated immediate operand, 0: shifted register |
| imm8 | input | 8 | Immediate byte |
| imm_rot | input | 4 | Immediate rotate field (half the amount) |
| sh_type | input | 2 | Shift type |
| sh_amt | input | 8 | Shift amount (instruction or register byte) |
| sh_by_reg | input | 1 | Shift amount comes from a register |
| rn_idx | input | 4 | First operand index |
| rn_val | input | 32 | First operand value |
| rm_idx | input | 4 | Second operand index |
| rm_val | input | 32 | Second operand value |
| instr_addr | input | 32 | Address of the instruction |
| cur_mode | input | 5 | Current processor mode |
| cpsr_in | input | 32 | Current status word |
| spsr_in | input | 32 | Saved status word of the current mode |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | ALU result |
| res_rd | output | 4 | Destination index of the result |
| rf_we | output | 1 | Register file write enable |
| pc_we | output | 1 | Program counter write enable |
| cpsr_next | output | 32 | Next status word |

## Verification
The assertions check the writeback rules on every cycle: the ways an accepted instruction may write the PC, the register file or the status word, that test opcodes never write, and that a stalled result stays stable. The shifter corner cases, the flag values produced by the ALU, the PC read offsets and the immediate rotation depend on exact data values. Only the bench's scenarios show these, comparing each result against hand-derived expectations, including a stall held for several cycles.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
  localparam int DW    = 32;
  localparam int RIW   = 4;
  localparam int MODEW = 5;

  localparam logic [RIW-1:0]   PC_IDX   = 4'd15;
  localparam logic [MODEW-1:0] USR_MODE = 5'b10000;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } dp_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
  } sh_type_e;

  // flag positions inside the status word
  localparam int FN = 31;
  localparam int FZ = 30;
  localparam int FC = 29;
  localparam int FV = 28;
endpackage

// File: rtl/dpu_shifter.sv
module dpu_shifter #(
  parameter int W    = dpu_pkg::DW,
  parameter int IMMW = 8,
  parameter int ROTW = 4
) (
  input  logic            use_imm,
  input  logic [IMMW-1:0] imm8,
  input  logic [ROTW-1:0] imm_rot,
  input  logic [1:0]      sh_type,
  input  logic [7:0]      sh_amt,
  input  logic            sh_by_reg,
  input  logic [W-1:0]    rm_v,
  input  logic            c_in,
  output logic [W-1:0]    op2,
  output logic            c_out
);
  import dpu_pkg::*;
  localparam int SW = $clog2(W);

  logic [W-1:0]     imm_ext;
  logic [2*W-1:0]   imm_rotd;
  logic [SW-1:0]    rot_amt;
  logic [8:0]       n;
  logic [W:0]       lsl_v, lsr_v;
  logic signed [W:0] asr_src, asr_v;
  logic [2*W-1:0]   ror_v;
  logic             imm_amt_zero;

  assign imm_ext      = {{(W-IMMW){1'b0}}, imm8};
  assign rot_amt      = SW'({imm_rot, 1'b0});
  assign imm_rotd     = {imm_ext, imm_ext} >> rot_amt;
  assign imm_amt_zero = (sh_amt[SW-1:0] == '0);

  always_comb begin
    if (sh_by_reg)
      n = {1'b0, sh_amt};
    else if (imm_amt_zero && (sh_type == SH_LSR || sh_type == SH_ASR))
      n = 9'(W);
    else
      n = 9'(sh_amt[SW-1:0]);
  end

  assign lsl_v   = {1'b0, rm_v} << n;
  assign lsr_v   = {rm_v, 1'b0} >> n;
  assign asr_src = {rm_v, 1'b0};
  assign asr_v   = asr_src >>> n;
  assign ror_v   = {rm_v, rm_v} >> n[SW-1:0];

  always_comb begin
    op2   = rm_v;
    c_out = c_in;
    if (use_imm) begin
      op2   = imm_rotd[W-1:0];
      c_out = (imm_rot == '0) ? c_in : imm_rotd[W-1];
    end else if (!sh_by_reg && sh_type == SH_ROR && imm_amt_zero) begin
      op2   = {c_in, rm_v[W-1:1]};
      c_out = rm_v[0];
    end else if (n != '0) begin
      unique case (sh_type)
        SH_LSL: begin op2 = lsl_v[W-1:0];      c_out = lsl_v[W]; end
        SH_LSR: begin op2 = lsr_v[W:1];        c_out = lsr_v[0]; end
        SH_ASR: begin op2 = asr_v[W:1];        c_out = asr_v[0]; end
        default: begin op2 = ror_v[W-1:0];     c_out = ror_v[W-1]; end
      endcase
    end
  end
endmodule

// File: rtl/dpu_alu.sv
module dpu_alu #(
  parameter int W = dpu_pkg::DW
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  input  logic         v_in,
  input  logic         sh_c,
  output logic [W-1:0] res,
  output logic [3:0]   nzcv
);
  import dpu_pkg::*;

  logic [W-1:0] x, y;
  logic         ci, arith;
  logic [W:0]   sum;
  logic         ovf;

  always_comb begin
    arith = 1'b1;
    x = a; y = b; ci = 1'b0;
    unique case (dp_op_e'(op))
      OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
      OP_ADD, OP_CMN: ;
      OP_ADC:         ci = c_in;
      OP_SBC:         begin y = ~b; ci = c_in; end
      OP_RSC:         begin x = b; y = ~a; ci = c_in; end
      default:        arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

  always_comb begin
    unique case (dp_op_e'(op))
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = sum[W-1:0];
    endcase
  end

  assign nzcv = {res[W-1], (res == '0),
                 arith ? sum[W] : sh_c,
                 arith ? ovf : v_in};
endmodule

// File: rtl/dpu_wb.sv
module dpu_wb #(
  parameter int W = dpu_pkg::DW
) (
  input  logic [3:0]              op,
  input  logic                    set_flags,
  input  logic [dpu_pkg::RIW-1:0] rd_idx,
  input  logic [dpu_pkg::MODEW-1:0] cur_mode,
  input  logic [W-1:0]            cpsr_in,
  input  logic [W-1:0]            spsr_in,
  input  logic [3:0]              nzcv,
  output logic                    rf_we,
  output logic                    pc_we,
  output logic [W-1:0]            cpsr_next
);
  import dpu_pkg::*;

  logic is_test, rd_pc, priv;
  logic [W-1:0] flagged;

  assign is_test = (op[3:2] == 2'b10);
  assign rd_pc   = (rd_idx == PC_IDX);
  assign priv    = (cur_mode != USR_MODE);
  assign rf_we   = !is_test && !rd_pc;
  assign pc_we   = !is_test && rd_pc;
  assign flagged = {nzcv, cpsr_in[FV-1:0]};

  always_comb begin
    cpsr_next = cpsr_in;
    if (is_test) begin
      if (dp_op_e'(op) == OP_TEQ && rd_pc) begin
        if (priv) cpsr_next = spsr_in;
      end else begin
        cpsr_next = flagged;
      end
    end else if (set_flags) begin
      if (rd_pc) begin
        if (priv) cpsr_next = spsr_in;
      end else begin
        cpsr_next = flagged;
      end
    end
  end
endmodule

// File: rtl/dpu_exec.sv
module dpu_exec #(
  parameter int W          = dpu_pkg::DW,
  parameter int PC_OFS_IMM = 8,
  parameter int PC_OFS_REG = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [3:0]  op,
  input  logic        set_flags,
  input  logic [3:0]  rd_idx,
  input  logic        use_imm,
  input  logic [7:0]  imm8,
  input  logic [3:0]  imm_rot,
  input  logic [1:0]  sh_type,
  input  logic [7:0]  sh_amt,
  input  logic        sh_by_reg,
  input  logic [3:0]  rn_idx,
  input  logic [W-1:0] rn_val,
  input  logic [3:0]  rm_idx,
  input  logic [W-1:0] rm_val,
  input  logic [W-1:0] instr_addr,
  input  logic [4:0]  cur_mode,
  input  logic [W-1:0] cpsr_in,
  input  logic [W-1:0] spsr_in,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [W-1:0] res_data,
  output logic [3:0]  res_rd,
  output logic        rf_we,
  output logic        pc_we,
  output logic [W-1:0] cpsr_next
);
  import dpu_pkg::*;

  logic [W-1:0] pc_read, rn_eff, rm_eff, op2, alu_res, cpsr_c;
  logic         sh_c, rf_we_c, pc_we_c, accept;
  logic [3:0]   nzcv;

  assign pc_read = instr_addr + ((!use_imm && sh_by_reg) ? W'(PC_OFS_REG) : W'(PC_OFS_IMM));
  assign rn_eff  = (rn_idx == PC_IDX) ? pc_read : rn_val;
  assign rm_eff  = (rm_idx == PC_IDX) ? pc_read : rm_val;

  dpu_shifter #(.W(W)) shifter_i (
    .use_imm(use_imm), .imm8(imm8), .imm_rot(imm_rot), .sh_type(sh_type),
    .sh_amt(sh_amt), .sh_by_reg(sh_by_reg), .rm_v(rm_eff), .c_in(cpsr_in[FC]),
    .op2(op2), .c_out(sh_c)
  );

  dpu_alu #(.W(W)) alu_i (
    .op(op), .a(rn_eff), .b(op2), .c_in(cpsr_in[FC]), .v_in(cpsr_in[FV]),
    .sh_c(sh_c), .res(alu_res), .nzcv(nzcv)
  );

  dpu_wb #(.W(W)) wb_i (
    .op(op), .set_flags(set_flags), .rd_idx(rd_idx), .cur_mode(cur_mode),
    .cpsr_in(cpsr_in), .spsr_in(spsr_in), .nzcv(nzcv),
    .rf_we(rf_we_c), .pc_we(pc_we_c), .cpsr_next(cpsr_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_data  <= '0;
      res_rd    <= '0;
      rf_we     <= 1'b0;
      pc_we     <= 1'b0;
      cpsr_next <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_data  <= alu_res;
      res_rd    <= rd_idx;
      rf_we     <= rf_we_c;
      pc_we     <= pc_we_c;
      cpsr_next <= cpsr_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dpu_exec_chk.sv
module dpu_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  op,
  input logic        set_flags,
  input logic [3:0]  rd_idx,
  input logic [4:0]  cur_mode,
  input logic [31:0] cpsr_in,
  input logic [31:0] spsr_in,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] res_data,
  input logic        rf_we,
  input logic        pc_we,
  input logic [31:0] cpsr_next
);
  logic acc, tst, to_pc, usr;
  assign acc   = in_valid && in_ready;
  assign tst   = (op[3:2] == 2'b10);
  assign to_pc = (rd_idx == 4'd15);
  assign usr   = (cur_mode == 5'b10000);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_data) && $stable(cpsr_next)
                                && $stable(rf_we) && $stable(pc_we));
  // R12
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  // R10
  test_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && tst |=> !rf_we && !pc_we);
  // R7
  pc_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !tst && to_pc && !set_flags |=> pc_we && !rf_we && cpsr_next == $past(cpsr_in));
  // R8
  pc_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !tst && to_pc && set_flags && !usr |=> pc_we && cpsr_next == $past(spsr_in));
  // R8
  pc_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !tst && to_pc && set_flags && usr |=> pc_we && cpsr_next == $past(cpsr_in));
  // R6
  reg_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !tst && !to_pc && !set_flags |=> rf_we && cpsr_next == $past(cpsr_in));
  // R6
  reg_lowbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !to_pc |=> cpsr_next[27:0] == $past(cpsr_in[27:0]));
  // R11
  teq_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'd9 && to_pc && usr |=> cpsr_next == $past(cpsr_in));
endmodule

bind dpu_exec dpu_exec_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op(op), .set_flags(set_flags), .rd_idx(rd_idx), .cur_mode(cur_mode),
  .cpsr_in(cpsr_in), .spsr_in(spsr_in), .out_valid(out_valid),
  .out_ready(out_ready), .res_data(res_data), .rf_we(rf_we), .pc_we(pc_we),
  .cpsr_next(cpsr_next)
);

// File: tb/dpu_exec_tb_top.sv
module dpu_exec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        in_valid, in_ready, set_flags, use_imm, sh_by_reg;
  logic [3:0]  op, rd_idx, imm_rot, rn_idx, rm_idx;
  logic [7:0]  imm8, sh_amt;
  logic [1:0]  sh_type;
  logic [31:0] rn_val, rm_val, instr_addr, cpsr_in, spsr_in;
  logic [4:0]  cur_mode;
  logic        out_valid, out_ready, rf_we, pc_we;
  logic [31:0] res_data, cpsr_next;
  logic [3:0]  res_rd;

  dpu_exec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .set_flags(set_flags), .rd_idx(rd_idx), .use_imm(use_imm),
    .imm8(imm8), .imm_rot(imm_rot), .sh_type(sh_type), .sh_amt(sh_amt),
    .sh_by_reg(sh_by_reg), .rn_idx(rn_idx), .rn_val(rn_val), .rm_idx(rm_idx),
    .rm_val(rm_val), .instr_addr(instr_addr), .cur_mode(cur_mode),
    .cpsr_in(cpsr_in), .spsr_in(spsr_in), .out_valid(out_valid),
    .out_ready(out_ready), .res_data(res_data), .res_rd(res_rd),
    .rf_we(rf_we), .pc_we(pc_we), .cpsr_next(cpsr_next)
  );

  typedef struct {
    logic [31:0] res;
    logic        rf;
    logic        pc;
    logic [31:0] cpsr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [3:0] AND_=0, SUB_=2, RSB_=3, ADD_=4, ADC_=5, SBC_=6,
                         TEQ_=9, CMP_=10, MOV_=13, BIC_=14;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    op = MOV_; set_flags = 0; rd_idx = 4'd1; use_imm = 1; imm8 = 0; imm_rot = 0;
    sh_type = 0; sh_amt = 0; sh_by_reg = 0; rn_idx = 4'd0; rn_val = 0;
    rm_idx = 4'd0; rm_val = 0; instr_addr = 32'h100; cur_mode = 5'h13;
    cpsr_in = 32'h13; spsr_in = 32'h0;
  endtask

  // driver: present the current fields, push the expectation at acceptance
  task automatic send(input logic [31:0] e_res, input logic e_rf, input logic e_pc,
                      input logic [31:0] e_cpsr, input string tag);
    exp_t e;
    bit rdy;
    e.res = e_res; e.rf = e_rf; e.pc = e_pc; e.cpsr = e_cpsr; e.tag = tag;
    in_valid = 1;
    do begin
      @(negedge clk); rdy = in_ready;
      @(posedge clk);
    end while (!rdy);
    exp_q.push_back(e);
    #1 in_valid = 0;
    defaults();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "unexpected result", res_data, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(res_data == e.res, {e.tag, " res"}, res_data, e.res);
        chk(rf_we == e.rf && pc_we == e.pc, {e.tag, " we"}, {30'b0, rf_we, pc_we}, {30'b0, e.rf, e.pc});
        chk(cpsr_next == e.cpsr, {e.tag, " cpsr"}, cpsr_next, e.cpsr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    in_valid = 0; out_ready = 1;
    defaults();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R12 reset out_valid", {31'b0, out_valid}, 0);
    chk(in_ready == 1, "R12 reset in_ready", {31'b0, in_ready}, 1);
    @(posedge clk); #1;

    // R1 immediate rotate: 0xFF ror 8, carry = bit31
    set_flags = 1; imm8 = 8'hFF; imm_rot = 4'd4;
    send(32'hFF000000, 1, 0, 32'hA0000013, "R1 rot8");
    // R1 rotate field zero keeps C, R4 V kept
    set_flags = 1; cpsr_in = 32'h30000013;
    send(32'h0, 1, 0, 32'h70000013, "R1 rot0 carry");
    // R5 ADD overflow
    op = ADD_; set_flags = 1; rn_val = 32'h7FFFFFFF; imm8 = 1;
    send(32'h80000000, 1, 0, 32'h90000013, "R5 add ovf");
    // R5 SUB equal
    op = SUB_; set_flags = 1; rn_val = 5; imm8 = 5;
    send(32'h0, 1, 0, 32'h60000013, "R5 sub eq");
    // R5 SUB borrow
    op = SUB_; set_flags = 1; rn_val = 3; imm8 = 5;
    send(32'hFFFFFFFE, 1, 0, 32'h80000013, "R5 sub borrow");
    // R3 RSB
    op = RSB_; set_flags = 1; rn_val = 3; imm8 = 5;
    send(32'h2, 1, 0, 32'h20000013, "R3 rsb");
    // R6 ADC without S: status unchanged
    op = ADC_; rn_val = 1; imm8 = 1; cpsr_in = 32'h20000013;
    send(32'h3, 1, 0, 32'h20000013, "R6 adc noS");
    // R5 SBC with C clear
    op = SBC_; set_flags = 1; rn_val = 5; imm8 = 2;
    send(32'h2, 1, 0, 32'h20000013, "R5 sbc");
    // R2 LSL #1
    set_flags = 1; use_imm = 0; rm_val = 32'h80000001; sh_type = 0; sh_amt = 1;
    send(32'h2, 1, 0, 32'h20000013, "R2 lsl1");
    // R2 LSR #0 means 32
    set_flags = 1; use_imm = 0; rm_val = 32'h80000000; sh_type = 1; sh_amt = 0;
    send(32'h0, 1, 0, 32'h60000013, "R2 lsr32");
    // R2 ASR #4
    set_flags = 1; use_imm = 0; rm_val = 32'h80000000; sh_type = 2; sh_amt = 4;
    send(32'hF8000000, 1, 0, 32'h80000013, "R2 asr4");
    // R2 ROR by register 4
    set_flags = 1; use_imm = 0; rm_val = 32'hF; sh_type = 3; sh_amt = 4; sh_by_reg = 1;
    send(32'hF0000000, 1, 0, 32'hA0000013, "R2 ror reg");
    // R4 BIC keeps V, C from rot0 = current C
    op = BIC_; set_flags = 1; rn_val = 32'hFF; imm8 = 8'h0F; cpsr_in = 32'h10000013;
    send(32'hF0, 1, 0, 32'h10000013, "R4 bic");
    // R9 PC reads
    op = ADD_; rd_idx = 2; rn_idx = 15;
    send(32'h108, 1, 0, 32'h13, "R9 pc+8");
    op = ADD_; rd_idx = 2; rn_idx = 15; use_imm = 0; sh_by_reg = 1; rm_idx = 3;
    send(32'h10C, 1, 0, 32'h13, "R9 pc+12");
    rd_idx = 2; use_imm = 0; rm_idx = 15; instr_addr = 32'h200;
    send(32'h208, 1, 0, 32'h13, "R9 rm pc+8");
    // R10 CMP without S still sets flags, no write
    op = CMP_; rd_idx = 0; rn_val = 5; imm8 = 5;
    send(32'h0, 0, 0, 32'h60000013, "R10 cmp");
    // R7 PC write without S
    rd_idx = 15; imm8 = 8'h40;
    send(32'h40, 0, 1, 32'h13, "R7 pc noS");
    // R8 privileged restore
    rd_idx = 15; set_flags = 1; imm8 = 8'h40; spsr_in = 32'hF0000010;
    send(32'h40, 0, 1, 32'hF0000010, "R8 restore");
    // R8 user mode: unchanged
    rd_idx = 15; set_flags = 1; cur_mode = 5'h10; cpsr_in = 32'h10; spsr_in = 32'hF000001F;
    send(32'h0, 0, 1, 32'h10, "R8 user");
    // R11 TEQ to 15 privileged
    op = TEQ_; rd_idx = 15; rn_val = 1; imm8 = 1; spsr_in = 32'h50000010;
    send(32'h0, 0, 0, 32'h50000010, "R11 teq priv");
    // R11 TEQ to 15 user
    op = TEQ_; rd_idx = 15; rn_val = 1; imm8 = 1; cur_mode = 5'h10; cpsr_in = 32'h10;
    spsr_in = 32'hF0000013;
    send(32'h0, 0, 0, 32'h10, "R11 teq user");

    // R12 back-pressure: result held, in_ready low
    wait (exp_q.size() == 0);
    @(posedge clk); #1 out_ready = 0;
    op = AND_; rn_val = 32'hF0F0; imm8 = 8'hFF;
    send(32'hF0, 1, 0, 32'h13, "R12 stalled and");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1 && in_ready == 0, "R12 stall", {30'b0, out_valid, in_ready}, 32'h2);
    chk(res_data == 32'hF0, "R12 held data", res_data, 32'hF0);
    @(posedge clk); #1 out_ready = 1;
    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    summary();
  end
endmodule